// File: doc/BRIEF.md
# Protection Region Table Access Unit

This block keeps the region descriptors of a memory protection unit in two banks: one for instruction regions and one for data regions. Software never addresses the table directly. It programs two 32-bit control registers instead. The *locator* register selects an entry: it holds a region base address, a bank select bit and a region index. The *attribute* register holds the region's upper bound (a mask or a limit, chosen at build time), a memory-type bit, a permission field and two one-shot strobes. Setting the store strobe copies the staged descriptor into the selected entry. Setting the fetch strobe loads the selected entry back into both registers.

Every register write is cleaned against the build-time geometry. Address bits below the minimum region size, address bits above the implemented address width, and index bits beyond a bank's region count are dropped. They read back as zero. The register port is plain control: a write is accepted on every cycle that `cfg_we` is high, and there is no back-pressure. Both registers are always visible on the outputs.

Top module: `prt_access_unit`

## Requirements
- R1: After reset both registers read zero and every table entry is all zeros. Fetching any entry after reset returns a zero base field and a zero attribute register.
- R2: A locator write (`cfg_sel`=0) stores the base field in bits 30..6. Only base bits from log2(MIN_REGION) up to ADDR_W-1 are kept; all other bits in 30..6 read zero, and bit 31 reads zero. The registers change only on a write.
- R3: Locator bit 5 selects the bank (1 = data, 0 = instruction). Bits 4..0 hold the index. Index bits at or above log2 of the selected bank's region count are cleared.
- R4: An attribute write (`cfg_sel`=1) keeps the memory-type bit at bit 5 and the permission field at bits 4..2. Bit 6 is reserved and reads zero. The upper-bound field occupies the high bits starting at bit log2(MIN_REGION).
- R5: Attribute bit 0 is the store strobe and bit 1 is the fetch strobe. Both always read back as zero.
- R6: A store strobe writes the locator's base field together with the written upper bound, memory type and permissions into the selected entry, at the same clock edge that captures the write.
- R7: A fetch strobe (without a store strobe) replaces the base field and all attribute fields with the selected entry's contents at the next edge. The locator's index and bank bits are left unchanged.
- R8: If the store and fetch strobes are set in the same write, the store takes place, no fetch happens, and the attribute register takes the written fields.
- R9: The instruction and data banks are independent: a store to an index in one bank leaves the same index in the other bank unchanged.
- R10: In the limit form (USE_LIMIT=1) the upper-bound field keeps address bits up to ADDR_W. In the mask form it keeps bits only up to ADDR_W-1, so it is one bit narrower.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register select: 0 locator, 1 attribute |
| cfg_wdata | input | 32 | Register write data |
| base_q | output | 32 | Locator register contents |
| acc_q | output | 32 | Attribute register contents |

## Verification
Every result of this block is due one rising edge after the write that causes it. This covers a cleaned register value, a stored entry, and the base and attributes loaded by a fetch. The bench therefore drives a write on a falling edge and compares both registers on the next falling edge, when the edge in between has already taken effect. A behavioural model follows every edge and is compared on every cycle. Directed fetches then bring stored entries out through the attribute and locator registers and check them against hand-computed values. Two instances, one per upper-bound form, receive the same stimulus so that the width difference is seen on the same cycle.

// File: rtl/prt_pkg.sv
package prt_pkg;

  localparam int REG_W    = 32;
  localparam int BASE_LO  = 6;
  localparam int BASE_HI  = 30;
  localparam int IDX_W    = 5;
  localparam int BANK_BIT = 5;
  localparam int WR_BIT   = 0;
  localparam int RD_BIT   = 1;
  localparam int PERM_LO  = 2;
  localparam int PERM_W   = 3;
  localparam int MT_BIT   = 5;
  localparam int RSVD_BIT = 6;

  // bits lo..hi inclusive set; empty when hi < lo
  function automatic logic [REG_W-1:0] range_mask(input int lo, input int hi);
    logic [REG_W-1:0] m;
    m = '0;
    for (int b = 0; b < REG_W; b++) begin
      if (b >= lo && b <= hi) m[b] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] BASE_FIELD = range_mask(BASE_LO, BASE_HI);

  typedef struct packed {
    logic [REG_W-1:0]  base;
    logic [REG_W-1:0]  lim;
    logic [PERM_W-1:0] perm;
    logic              mtype;
  } entry_t;

endpackage

// File: rtl/prt_sanitize.sv
module prt_sanitize
  import prt_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int MIN_LG    = 10,
  parameter bit USE_LIMIT = 1'b1,
  parameter int I_IW      = 3,
  parameter int D_IW      = 4
) (
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  base_clean,
  output logic [REG_W-1:0]  lim_clean,
  output logic [PERM_W-1:0] perm_clean,
  output logic              mt_clean,
  output logic              wr_stb,
  output logic              rd_stb
);

  localparam logic [REG_W-1:0] BASE_KEEP =
    range_mask(MIN_LG, ADDR_W-1) & BASE_FIELD;
  localparam logic [IDX_W-1:0] I_IDX_KEEP = IDX_W'(range_mask(0, I_IW-1));
  localparam logic [IDX_W-1:0] D_IDX_KEEP = IDX_W'(range_mask(0, D_IW-1));

  logic [IDX_W-1:0] idx_keep;
  logic             bank;

  assign bank     = wdata[BANK_BIT];
  assign idx_keep = bank ? D_IDX_KEEP : I_IDX_KEEP;

  always_comb begin
    base_clean                 = wdata & BASE_KEEP;
    base_clean[BANK_BIT]       = bank;
    base_clean[IDX_W-1:0]      = wdata[IDX_W-1:0] & idx_keep;
  end

  generate
    if (USE_LIMIT) begin : g_limit
      localparam logic [REG_W-1:0] UB_KEEP = range_mask(MIN_LG, ADDR_W);
      assign lim_clean = wdata & UB_KEEP;
    end else begin : g_mask
      localparam logic [REG_W-1:0] UB_KEEP = range_mask(MIN_LG, ADDR_W-1);
      assign lim_clean = wdata & UB_KEEP;
    end
  endgenerate

  assign perm_clean = wdata[PERM_LO +: PERM_W];
  assign mt_clean   = wdata[MT_BIT];
  assign wr_stb     = wdata[WR_BIT];
  assign rd_stb     = wdata[RD_BIT];

endmodule

// File: rtl/prt_bank.sv
module prt_bank
  import prt_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  entry_t        wentry,
  output entry_t        rentry
);

  entry_t slot [N];

  generate
    for (genvar g = 0; g < N; g++) begin : g_ent
      entry_t ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      ent_q <= '0;
        else if (we && idx == IW'(g))    ent_q <= wentry;
      end
      assign slot[g] = ent_q;
    end
  endgenerate

  assign rentry = slot[idx];

  // R6: the addressed entry holds the presented descriptor after the edge
  p_store_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> slot[$past(idx)] == $past(wentry));

  // R9: an entry not addressed by a store keeps its contents
  p_other_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx != IW'(0)) |=> $stable(slot[0]));

endmodule

// File: rtl/prt_ctrl.sv
module prt_ctrl
  import prt_pkg::*;
#(
  parameter int I_IW = 3,
  parameter int D_IW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [REG_W-1:0]  base_clean,
  input  logic [REG_W-1:0]  lim_clean,
  input  logic [PERM_W-1:0] perm_clean,
  input  logic              mt_clean,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  entry_t            i_rentry,
  input  entry_t            d_rentry,
  output logic              i_we,
  output logic              d_we,
  output entry_t            wentry,
  output logic [I_IW-1:0]   i_idx,
  output logic [D_IW-1:0]   d_idx,
  output logic [REG_W-1:0]  base_q,
  output logic [REG_W-1:0]  acc_q
);

  logic [REG_W-1:0]  base_r;
  logic [REG_W-1:0]  lim_r;
  logic [PERM_W-1:0] perm_r;
  logic              mt_r;
  logic              bank_r;
  logic              loc_wr;
  logic              att_wr;
  logic              wr_fire;
  logic              rd_fire;
  entry_t            sel_entry;

  assign bank_r  = base_r[BANK_BIT];
  assign i_idx   = base_r[I_IW-1:0];
  assign d_idx   = base_r[D_IW-1:0];
  assign loc_wr  = cfg_we && !cfg_sel;
  assign att_wr  = cfg_we && cfg_sel;
  assign wr_fire = att_wr && wr_stb;
  assign rd_fire = att_wr && rd_stb && !wr_stb;

  assign i_we = wr_fire && !bank_r;
  assign d_we = wr_fire &&  bank_r;

  always_comb begin
    sel_entry = bank_r ? d_rentry : i_rentry;
    wentry.base  = base_r & BASE_FIELD;
    wentry.lim   = lim_clean;
    wentry.perm  = perm_clean;
    wentry.mtype = mt_clean;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_r <= '0;
      lim_r  <= '0;
      perm_r <= '0;
      mt_r   <= 1'b0;
    end else if (loc_wr) begin
      base_r <= base_clean;
    end else if (rd_fire) begin
      base_r <= (base_r & ~BASE_FIELD) | (sel_entry.base & BASE_FIELD);
      lim_r  <= sel_entry.lim;
      perm_r <= sel_entry.perm;
      mt_r   <= sel_entry.mtype;
    end else if (att_wr) begin
      lim_r  <= lim_clean;
      perm_r <= perm_clean;
      mt_r   <= mt_clean;
    end
  end

  assign base_q = base_r;

  always_comb begin
    acc_q                      = lim_r;
    acc_q[MT_BIT]              = mt_r;
    acc_q[PERM_LO +: PERM_W]   = perm_r;
  end

  // R7: a fetch loads the selected entry by the next edge
  p_fetch_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ((base_q & BASE_FIELD) == ($past(sel_entry.base) & BASE_FIELD))
             && (acc_q[PERM_LO +: PERM_W] == $past(sel_entry.perm))
             && (acc_q[MT_BIT] == $past(sel_entry.mtype)));

  // R7: index and bank survive a fetch
  p_fetch_keeps_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> $stable(base_q[BANK_BIT:0]));

  // R8: both strobes together store and leave the locator untouched
  p_store_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (att_wr && wr_stb && rd_stb) |=> $stable(base_q) && $past(i_we || d_we));

  // R6: a store strobe enables exactly one bank
  p_one_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> $countones({i_we, d_we}) == 1);

  // R2: registers only change on a write
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(base_q) && $stable(acc_q));

endmodule

// File: rtl/prt_access_unit.sv
module prt_access_unit
  import prt_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int MIN_LG    = 10,
  parameter int I_REGIONS = 8,
  parameter int D_REGIONS = 16,
  parameter bit USE_LIMIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  base_q,
  output logic [REG_W-1:0]  acc_q
);

  localparam int I_IW = $clog2(I_REGIONS);
  localparam int D_IW = $clog2(D_REGIONS);

  logic [REG_W-1:0]  base_clean;
  logic [REG_W-1:0]  lim_clean;
  logic [PERM_W-1:0] perm_clean;
  logic              mt_clean;
  logic              wr_stb;
  logic              rd_stb;
  logic              i_we;
  logic              d_we;
  logic [I_IW-1:0]   i_idx;
  logic [D_IW-1:0]   d_idx;
  entry_t            wentry;
  entry_t            i_rentry;
  entry_t            d_rentry;

  prt_sanitize #(
    .ADDR_W(ADDR_W), .MIN_LG(MIN_LG), .USE_LIMIT(USE_LIMIT),
    .I_IW(I_IW), .D_IW(D_IW)
  ) u_sanitize (
    .wdata(cfg_wdata), .base_clean(base_clean), .lim_clean(lim_clean),
    .perm_clean(perm_clean), .mt_clean(mt_clean),
    .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  prt_ctrl #(.I_IW(I_IW), .D_IW(D_IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .base_clean(base_clean), .lim_clean(lim_clean), .perm_clean(perm_clean),
    .mt_clean(mt_clean), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .i_rentry(i_rentry), .d_rentry(d_rentry),
    .i_we(i_we), .d_we(d_we), .wentry(wentry),
    .i_idx(i_idx), .d_idx(d_idx), .base_q(base_q), .acc_q(acc_q)
  );

  prt_bank #(.N(I_REGIONS), .IW(I_IW)) u_ibank (
    .clk(clk), .rst_n(rst_n), .we(i_we), .idx(i_idx),
    .wentry(wentry), .rentry(i_rentry)
  );

  prt_bank #(.N(D_REGIONS), .IW(D_IW)) u_dbank (
    .clk(clk), .rst_n(rst_n), .we(d_we), .idx(d_idx),
    .wentry(wentry), .rentry(d_rentry)
  );

endmodule

// File: tb/prt_access_unit_bench.sv
module prt_access_unit_bench;

  localparam logic [31:0] BASE_KEEP = 32'h0FFF_FC00;
  localparam logic [31:0] BFIELD    = 32'h7FFF_FFC0;
  localparam logic [31:0] LIM_KEEP  = 32'h1FFF_FC00;
  localparam logic [31:0] LOW_KEEP  = 32'h0000_003C;
  localparam logic [31:0] TOP_LIM   = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] base_q, acc_q, base_q_m, acc_q_m;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 0;

  logic [31:0] m_base, m_acc;
  logic [31:0] eb [2][32];
  logic [31:0] ea [2][32];

  always #10 clk = ~clk;

  prt_access_unit u_prt_access_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_q(base_q), .acc_q(acc_q));

  prt_access_unit #(.USE_LIMIT(1'b0)) u_prt_access_unit_mask (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_q(base_q_m), .acc_q(acc_q_m));

  function automatic logic [31:0] clean_base(input logic [31:0] w);
    logic [31:0] r;
    r = (w & BASE_KEEP) | (w & 32'h20);
    r[4:0] = w[4:0] & (w[5] ? 5'hF : 5'h7);
    return r;
  endfunction

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = '0;
      m_acc  = '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < 32; i++) begin eb[b][i] = '0; ea[b][i] = '0; end
    end else if (cfg_we) begin
      if (!cfg_sel) m_base = clean_base(cfg_wdata);
      else begin
        logic [31:0] a;
        int bk, ix;
        bk = int'(m_base[5]);
        ix = int'(m_base[4:0]);
        a  = cfg_wdata & (LIM_KEEP | LOW_KEEP);
        if (cfg_wdata[0]) begin
          eb[bk][ix] = m_base & BFIELD;
          ea[bk][ix] = a;
          m_acc = a;
        end else if (cfg_wdata[1]) begin
          m_base = (m_base & ~BFIELD) | eb[bk][ix];
          m_acc  = ea[bk][ix];
        end else m_acc = a;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, base_q, m_base);
      check(cur_req, acc_q, m_acc);
      check(cur_req, base_q_m, m_base);
      check(cur_req, acc_q_m, m_acc & ~TOP_LIM);
    end
  end

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put(input int bk, input int ix, input logic [31:0] bf, input logic [31:0] at);
    wr(1'b0, bf | (32'(bk) << 5) | 32'(ix));
    wr(1'b1, (at & ~32'h3) | 32'h1);
  endtask

  task automatic get(input int bk, input int ix);
    wr(1'b0, (32'(bk) << 5) | 32'(ix));
    wr(1'b1, 32'h2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", base_q, 32'h0);
    check("R1", acc_q, 32'h0);
    get(0, 5);
    check("R1", base_q, 32'h0000_0005);
    check("R1", acc_q, 32'h0);

    // R2, R3: locator cleaning, data bank then instruction bank
    cur_req = "R2";
    wr(1'b0, 32'hFFFF_FFFF);
    check("R2", base_q, 32'h0FFF_FC2F);
    check("R3", base_q[4:0], 5'hF);
    wr(1'b0, 32'hFFFF_FFDF);
    check("R3", base_q, 32'h0FFF_FC07);

    // R4, R5, R10: attribute cleaning and bound width
    cur_req = "R4";
    wr(1'b1, 32'hFFFF_FFFC);
    check("R4", acc_q, 32'h1FFF_FC3C);
    check("R10", acc_q_m, 32'h0FFF_FC3C);
    check("R4", 32'(acc_q[6]), 32'h0);
    cur_req = "R5";
    wr(1'b1, 32'h0000_0C01);
    check("R5", 32'(acc_q[1:0]), 32'h0);

    // R6, R7: store then fetch with a different staged base
    cur_req = "R6";
    put(1, 9, 32'h0ABC_D400, 32'h1234_5678);
    check("R6", acc_q, 32'h1234_5438);
    wr(1'b0, 32'h0111_1029);
    cur_req = "R7";
    wr(1'b1, 32'h2);
    check("R7", base_q, 32'h0ABC_D429);
    check("R7", acc_q, 32'h1234_5438);
    check("R10", acc_q_m, 32'h0234_5438);
    check("R7", 32'(base_q[5:0]), 32'h29);

    // R9: same index, both banks
    cur_req = "R9";
    put(0, 1, 32'h0000_0C00, 32'h0000_0C08);
    put(1, 1, 32'h07FF_F000, 32'h1FFF_F034);
    get(0, 1);
    check("R9", base_q, 32'h0000_0C01);
    check("R9", acc_q, 32'h0000_0C08);
    get(1, 1);
    check("R9", base_q, 32'h07FF_F021);
    check("R9", acc_q, 32'h1FFF_F034);

    // R8: both strobes in one write
    cur_req = "R8";
    wr(1'b0, 32'h0000_0002);
    wr(1'b1, 32'h0000_5C03);
    check("R8", acc_q, 32'h0000_5C00);
    check("R8", base_q, 32'h0000_0002);
    wr(1'b1, 32'h0);
    wr(1'b1, 32'h2);
    check("R8", acc_q, 32'h0000_5C00);

    // mixed traffic against the model
    cur_req = "R6";
    lf = 32'hACE1_2345;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      @(negedge clk);
      cfg_we    = lf[3] | lf[7];
      cfg_sel   = lf[11];
      cfg_wdata = {lf[15:0], lf[31:16]} ^ (lf[19] ? 32'h0 : 32'h3);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule